// File: doc/BRIEF.md
# Packed SIMD integer ALU

A purely combinational arithmetic unit for 64-bit packed integer data. Two source operands, `fs` and `ft`, are split into lanes of 8, 16, 32 or 64 bits, and one lane-wise operation is applied to every lane pair at once. The result lanes are packed back into one 64-bit result word. No lane's carry or borrow reaches its neighbour.

The operation set covers wrapping add and subtract, signed and unsigned saturating add and subtract, rounding unsigned average, minimum and maximum, equality and signed greater-than compares that return lane masks, absolute byte difference, and an and-not. A 6-bit opcode picks the operation and the lane size. Any combination outside the supported set yields a zero result, so a decoder upstream never sees undefined data. The unit sits between operand read and writeback in a media execution stage and holds no state.

Top module: `simd_int_alu`

## Requirements
- R1: The opcode is split into two fields. `op[5:2]` is the function code and `op[1:0]` is the lane size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. Function codes: 0 wrap add, 1 wrap subtract, 2 signed saturating add, 3 unsigned saturating add, 4 signed saturating subtract, 5 unsigned saturating subtract, 6 average, 7 maximum, 8 minimum, 9 equality compare, 10 signed greater-than compare, 11 absolute difference, 12 and-not.
- R2: Wrap add (0) and wrap subtract (1) compute `fs` lane plus/minus `ft` lane modulo 2^width, for all four lane sizes.
- R3: Signed saturating add (2) and subtract (4) are valid for 8- and 16-bit lanes. On overflow they clamp to the lane's most positive value (0x7F.., when the true result is too large) or to its most negative value (0x80.., when it is too small).
- R4: Unsigned saturating add (3), valid for 8- and 16-bit lanes, clamps to all ones when the sum exceeds the lane range.
- R5: Unsigned saturating subtract (5), valid for 8- and 16-bit lanes, clamps to zero when `ft` is greater than `fs` in a lane.
- R6: Average (6), valid for 8- and 16-bit lanes, returns (a+b+1)>>1 of the unsigned lane values, computed without losing the carry.
- R7: Maximum (7) and minimum (8) are valid for 8- and 16-bit lanes. They compare as signed numbers in 16-bit lanes and as unsigned numbers in 8-bit lanes.
- R8: Equality (9) and signed greater-than (`fs` > `ft`) (10) compares are valid for 8-, 16- and 32-bit lanes. Each result lane is all ones when the comparison is true and all zeros when it is false.
- R9: Absolute difference (11), valid for 8-bit lanes only, returns |a-b| of the unsigned byte values.
- R10: And-not (12) returns the bitwise `~fs & ft`, whatever the size field holds.
- R11: Lanes are independent: a carry or borrow never crosses a lane boundary.
- R12: Function codes 13 to 15, and any function code paired with a lane size not listed for it, give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 6 | Function code in bits 5:2, lane size in bits 1:0 |
| fs | input | 64 | First source operand |
| ft | input | 64 | Second source operand |
| y | output | 64 | Packed lane-wise result |

## Verification
The assertions in each lane check, whenever the inputs change, relations that hold for any operands:
- an unsigned saturating sum never falls below either addend;
- an unsigned saturating difference never exceeds the minuend;
- an average lies between its inputs;
- a maximum or minimum returns one of its two operands;
- an absolute difference never exceeds the larger byte;
- an and-not result shares no set bit with `fs`.

Only the bench's scenarios can show the exact values: the signed clamp points, the rounding of the average, signed versus unsigned ordering at each lane size, the compare masks, carry isolation at lane boundaries, and the zero result for unsupported opcodes.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

   localparam int FN_W    = 4;
   localparam int SIZE_W  = 2;
   localparam int OP_W    = FN_W + SIZE_W;
   localparam int N_SIZES = 1 << SIZE_W;
   localparam int BASE_LW = 8;

   typedef enum logic [FN_W-1:0] {
      FN_ADD   = 4'd0,
      FN_SUB   = 4'd1,
      FN_ADDSS = 4'd2,
      FN_ADDUS = 4'd3,
      FN_SUBSS = 4'd4,
      FN_SUBUS = 4'd5,
      FN_AVG   = 4'd6,
      FN_MAX   = 4'd7,
      FN_MIN   = 4'd8,
      FN_CMPEQ = 4'd9,
      FN_CMPGT = 4'd10,
      FN_ABSD  = 4'd11,
      FN_ANDN  = 4'd12
   } alu_fn_e;

   // lane size code -> lane width in bits
   function automatic int size_to_lw(input int sz);
      return BASE_LW << sz;
   endfunction

   // true when the function/lane-size pair is a supported operation
   function automatic logic fn_legal(input logic [FN_W-1:0] fn,
                                     input logic [SIZE_W-1:0] sz);
      logic ok;
      case (fn)
         FN_ADD, FN_SUB, FN_ANDN:                  ok = 1'b1;
         FN_ADDSS, FN_ADDUS, FN_SUBSS, FN_SUBUS,
         FN_AVG, FN_MAX, FN_MIN:                   ok = (sz <= 2'd1);
         FN_CMPEQ, FN_CMPGT:                       ok = (sz <= 2'd2);
         FN_ABSD:                                  ok = (sz == 2'd0);
         default:                                  ok = 1'b0;
      endcase
      return ok;
   endfunction

   // halfword lanes order min/max as signed, byte lanes as unsigned
   function automatic bit minmax_is_signed(input int lw);
      return (lw == 2 * BASE_LW);
   endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
   import simd_alu_pkg::*;
#(
   parameter int LW = 8
) (
   input  logic [FN_W-1:0] fn,
   input  logic [LW-1:0]   a,
   input  logic [LW-1:0]   b,
   output logic [LW-1:0]   r
);

   localparam bit         SIGNED_MM = minmax_is_signed(LW);
   localparam logic [LW-1:0] POS_MAX = {1'b0, {(LW-1){1'b1}}};
   localparam logic [LW-1:0] NEG_MIN = {1'b1, {(LW-1){1'b0}}};
   localparam int         MSB = LW - 1;

   generate
      if (LW < 2) begin : g_bad_lw
         $error("simd_lane: LW must be at least 2");
      end
   endgenerate

   logic [LW:0]   sum;
   logic [LW:0]   dif;
   logic [LW-1:0] neg_dif;
   logic          borrow;
   logic          ovf_add;
   logic          ovf_sub;
   logic          u_gt;
   logic          s_gt;
   logic          mm_gt;
   logic [LW-1:0] avg;
   logic [LW-1:0] hi_v;
   logic [LW-1:0] lo_v;

   always_comb begin
      sum     = {1'b0, a} + {1'b0, b};
      dif     = {1'b0, a} - {1'b0, b};
      neg_dif = b - a;
      borrow  = dif[LW];
      ovf_add = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      ovf_sub = (a[MSB] != b[MSB]) && (dif[MSB] != a[MSB]);
      u_gt    = !borrow && (a != b);
      s_gt    = (a[MSB] != b[MSB]) ? b[MSB] : u_gt;
      mm_gt   = SIGNED_MM ? s_gt : u_gt;
      // (a+b+1)>>1 : the upper bits of the sum plus the dropped bit
      avg     = sum[LW:1] + {{(LW-1){1'b0}}, sum[0]};
      hi_v    = (a > b) ? a : b;
      lo_v    = (a > b) ? b : a;

      case (fn)
         FN_ADD:   r = sum[LW-1:0];
         FN_SUB:   r = dif[LW-1:0];
         FN_ADDSS: r = ovf_add ? (a[MSB] ? NEG_MIN : POS_MAX) : sum[LW-1:0];
         FN_ADDUS: r = sum[LW] ? {LW{1'b1}} : sum[LW-1:0];
         FN_SUBSS: r = ovf_sub ? (a[MSB] ? NEG_MIN : POS_MAX) : dif[LW-1:0];
         FN_SUBUS: r = borrow ? '0 : dif[LW-1:0];
         FN_AVG:   r = avg;
         FN_MAX:   r = mm_gt ? a : b;
         FN_MIN:   r = mm_gt ? b : a;
         FN_CMPEQ: r = (a == b) ? {LW{1'b1}} : '0;
         FN_CMPGT: r = s_gt ? {LW{1'b1}} : '0;
         FN_ABSD:  r = borrow ? neg_dif : dif[LW-1:0];
         FN_ANDN:  r = ~a & b;
         default:  r = '0;
      endcase

      if (fn == FN_ADDUS) begin
         // R4
         adds_floor_chk: assert (r >= a && r >= b)
            else $error("unsigned saturating sum below an addend");
      end
      if (fn == FN_SUBUS) begin
         // R5
         subus_ceiling_chk: assert (r <= a)
            else $error("unsigned saturating difference above minuend");
      end
      if (fn == FN_AVG) begin
         // R6
         avg_between_chk: assert (r >= lo_v && r <= hi_v)
            else $error("average outside its operands");
      end
      if (fn == FN_MAX || fn == FN_MIN) begin
         // R7
         minmax_pick_chk: assert (r == a || r == b)
            else $error("min/max result is neither operand");
      end
      if (fn == FN_ABSD) begin
         // R9
         absd_bound_chk: assert (r <= hi_v)
            else $error("absolute difference above larger operand");
      end
      if (fn == FN_ANDN) begin
         // R10
         andn_disjoint_chk: assert ((r & a) == '0)
            else $error("and-not result overlaps fs");
      end
   end

endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
   import simd_alu_pkg::*;
#(
   parameter int DW = 64,
   parameter int LW = 8
) (
   input  logic [FN_W-1:0] fn,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   output logic [DW-1:0]   r
);

   localparam int N_LANES = DW / LW;

   generate
      if (DW % LW != 0) begin : g_bad_split
         $error("simd_lane_bank: DW must be a multiple of LW");
      end

      // R11: each lane owns its own adder; no carry leaves a lane
      for (genvar i = 0; i < N_LANES; i++) begin : g_lane
         simd_lane #(.LW(LW)) u_lane (
            .fn (fn),
            .a  (a[i*LW +: LW]),
            .b  (b[i*LW +: LW]),
            .r  (r[i*LW +: LW])
         );
      end
   endgenerate

endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu
   import simd_alu_pkg::*;
#(
   parameter int DW = 64
) (
   input  logic [OP_W-1:0] op,
   input  logic [DW-1:0]   fs,
   input  logic [DW-1:0]   ft,
   output logic [DW-1:0]   y
);

   logic [FN_W-1:0]   fn;
   logic [SIZE_W-1:0] sz;
   logic [DW-1:0]     bank_y [N_SIZES];

   generate
      if (DW % size_to_lw(N_SIZES - 1) != 0) begin : g_bad_dw
         $error("simd_int_alu: DW must be a multiple of the widest lane");
      end

      for (genvar g = 0; g < N_SIZES; g++) begin : g_bank
         simd_lane_bank #(.DW(DW), .LW(size_to_lw(g))) u_bank (
            .fn (fn),
            .a  (fs),
            .b  (ft),
            .r  (bank_y[g])
         );
      end
   endgenerate

   always_comb begin
      fn = op[OP_W-1:SIZE_W];
      sz = op[SIZE_W-1:0];
      // R12: unsupported pairs are forced to zero
      y  = fn_legal(fn, sz) ? bank_y[sz] : '0;
   end

endmodule

// File: tb/sim_simd_int_alu.sv
module sim_simd_int_alu;

   logic        clk = 1'b0;
   logic [5:0]  op  = '0;
   logic [63:0] fs  = '0;
   logic [63:0] ft  = '0;
   logic [63:0] y;

   int n_cmp  = 0;
   int n_bad  = 0;
   bit closed = 1'b0;

   typedef struct {
      logic [63:0] exp;
      logic [5:0]  op;
      string       tag;
   } sb_item_t;

   sb_item_t sbq[$];

   always #2.5 clk = ~clk;   // 200 MHz

   simd_int_alu u0 (.op(op), .fs(fs), .ft(ft), .y(y));

   // ---------------- reference model ----------------
   function automatic bit legal(int fn, int sz);
      case (fn)
         0, 1, 12:              return 1'b1;
         2, 3, 4, 5, 6, 7, 8:   return sz <= 1;
         9, 10:                 return sz <= 2;
         11:                    return sz == 0;
         default:               return 1'b0;
      endcase
   endfunction

   function automatic logic [63:0] model(logic [5:0] o, logic [63:0] a, logic [63:0] b);
      int fn = int'(o[5:2]);
      int sz = int'(o[1:0]);
      int lw = 8 << sz;
      int n  = 64 / lw;
      logic [63:0] res = '0;
      if (!legal(fn, sz)) return '0;
      if (fn == 12) return ~a & b;
      for (int i = 0; i < n; i++) begin
         longint unsigned m, ua, ub, r;
         longint sa, sb, hi, lo, t;
         m  = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
         ua = (a >> (i * lw)) & m;
         ub = (b >> (i * lw)) & m;
         if (lw < 64) begin
            hi = (longint'(1) <<< (lw - 1)) - 1;
            lo = -hi - 1;
            sa = ((ua >> (lw - 1)) & 1) != 0 ? longint'(ua) - (longint'(1) <<< lw) : longint'(ua);
            sb = ((ub >> (lw - 1)) & 1) != 0 ? longint'(ub) - (longint'(1) <<< lw) : longint'(ub);
         end else begin
            hi = 0; lo = 0; sa = 0; sb = 0;
         end
         r = 0;
         case (fn)
            0: r = ua + ub;
            1: r = ua - ub;
            2, 4: begin
               t = (fn == 2) ? sa + sb : sa - sb;
               if (t > hi) t = hi;
               if (t < lo) t = lo;
               r = longint'(t);
            end
            3: r = (ua + ub > m) ? m : ua + ub;
            5: r = (ua > ub) ? ua - ub : 0;
            6: r = (ua + ub + 1) >> 1;
            7, 8: begin
               bit agt;
               agt = (lw == 16) ? (sa > sb) : (ua > ub);
               r = ((fn == 7) == agt) ? ua : ub;
            end
            9:  r = (ua == ub) ? m : 0;
            10: r = (sa > sb) ? m : 0;
            11: r = (ua > ub) ? ua - ub : ub - ua;
            default: r = 0;
         endcase
         res = res | ((r & m) << (i * lw));
      end
      return res;
   endfunction

   function automatic string tag_of(int fn, int sz);
      if (!legal(fn, sz)) return "R12";
      case (fn)
         0, 1:   return "R2";
         2, 4:   return "R3";
         3:      return "R4";
         5:      return "R5";
         6:      return "R6";
         7, 8:   return "R7";
         9, 10:  return "R8";
         11:     return "R9";
         default: return "R10";
      endcase
   endfunction

   // ---------------- driver ----------------
   task automatic drive(logic [5:0] o, logic [63:0] a, logic [63:0] b, string tag);
      sb_item_t it;
      @(negedge clk);
      op = o; fs = a; ft = b;
      it.exp = model(o, a, b);
      it.op  = o;
      it.tag = tag;
      sbq.push_back(it);
   endtask

   function automatic logic [5:0] mk(int fn, int sz);
      return {4'(fn), 2'(sz)};
   endfunction

   function automatic logic [63:0] edgy();
      logic [63:0] v;
      for (int k = 0; k < 8; k++) begin
         case ($urandom % 6)
            0: v[k*8 +: 8] = 8'h00;
            1: v[k*8 +: 8] = 8'h7F;
            2: v[k*8 +: 8] = 8'h80;
            3: v[k*8 +: 8] = 8'hFF;
            default: v[k*8 +: 8] = 8'($urandom);
         endcase
      end
      return v;
   endfunction

   // ---------------- monitor ----------------
   always @(posedge clk) begin
      if (!closed && sbq.size() > 0) begin
         sb_item_t it;
         it = sbq.pop_front();
         n_cmp++;
         if (y !== it.exp) begin
            n_bad++;
            $display("FAIL %s op=%h actual=%h expected=%h", it.tag, it.op, y, it.exp);
         end
      end
   end

   task automatic finish_run();
      closed = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #1000000;
      if (!closed) begin
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      // idle state: zero opcode and operands give zero (R1, R2)
      drive(mk(0, 0), 64'h0, 64'h0, "R1 idle");
      // R1: same operands, size field changes lane split
      drive(mk(0, 0), 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "R1 bytes");
      drive(mk(0, 1), 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "R1 halves");
      // R11: no carry across lane edges
      drive(mk(0, 1), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, "R11 add");
      drive(mk(1, 2), 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, "R11 sub");
      drive(mk(0, 3), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R2 dword wrap");
      // R3 clamps
      drive(mk(2, 1), 64'h7FFF_8000_1234_7FFF, 64'h0001_FFFF_0001_7FFF, "R3 adds");
      drive(mk(4, 0), 64'h80_7F_00_80_7F_01_02_03, 64'h01_FF_80_7F_80_01_01_01, "R3 subs");
      // R4, R5
      drive(mk(3, 0), 64'hFF_80_01_00_FE_7F_10_FF, 64'h01_80_FF_00_01_01_10_FF, "R4 addus");
      drive(mk(5, 1), 64'h0001_FFFF_0000_8000, 64'h0002_0001_FFFF_8000, "R5 subus");
      // R6 rounding and carry
      drive(mk(6, 0), 64'hFF_00_01_02_FE_80_7F_03, 64'hFF_01_00_02_FF_80_80_04, "R6 avg b");
      drive(mk(6, 1), 64'hFFFF_0000_0001_8000, 64'hFFFF_0001_0002_7FFF, "R6 avg h");
      // R7 signedness by size
      drive(mk(7, 1), 64'h8000_0001_7FFF_FFFF, 64'h0001_8000_8000_0000, "R7 max h");
      drive(mk(8, 0), 64'h80_01_FF_00_7F_80_10_20, 64'h01_80_00_FF_80_7F_20_10, "R7 min b");
      // R8 masks
      drive(mk(10, 2), 64'h0000_0001_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF, "R8 gt w");
      drive(mk(9, 0), 64'h12_34_56_78_9A_BC_DE_F0, 64'h12_00_56_00_9A_00_DE_00, "R8 eq b");
      // R9
      drive(mk(11, 0), 64'h00_FF_10_20_80_7F_05_05, 64'hFF_00_20_10_7F_80_05_06, "R9 absd");
      // R10 with every size code
      for (int s = 0; s < 4; s++)
         drive(mk(12, s), 64'hF0F0_1234_AAAA_0000, 64'hFFFF_FFFF_5555_FFFF, "R10 andn");
      // R12 unsupported
      drive(mk(13, 0), 64'hFFFF, 64'h1, "R12 code13");
      drive(mk(15, 3), 64'hFFFF, 64'h1, "R12 code15");
      drive(mk(11, 1), 64'h00FF, 64'hFF00, "R12 absd h");
      drive(mk(9, 3), 64'h5, 64'h5, "R12 eq d");
      drive(mk(3, 2), 64'hFFFF_FFFF, 64'h1, "R12 addus w");
      // sweep every opcode with biased operands
      for (int rep = 0; rep < 60; rep++)
         for (int f = 0; f < 16; f++)
            for (int s = 0; s < 4; s++) begin
               logic [63:0] a;
               logic [63:0] b;
               a = edgy();
               b = (rep % 4 == 0) ? a : edgy();
               drive(mk(f, s), a, b, tag_of(f, s));
            end
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule